// File: doc/BRIEF.md
# Overcurrent Circuit Breaker Timer

This block holds the timing decisions of an inline current-sense breaker. Two comparator results arrive already digitised: one flag says the sensed current is above its nominal limit, the other says it is above the fast limit. From these, a slow timebase tick and a few configuration fields, the block decides when the breaker trips and when the analog side should pull back gate drive to hold the current down. It also tells the fast comparator which threshold to use.

Without regulation, a nominal overcurrent must persist, without a break, for a chosen number of ticks before it trips the breaker, so short spikes pass. The fast flag trips at once whenever the fast limit is switched on. With regulation enabled, a nominal overcurrent instead raises a regulate request. The request lasts for a bounded period. If the current recovers inside that period, the timer starts over. If it does not, the breaker trips. After a trip the block stays quiet until it is disabled and re-enabled.

Top module: `ocb_timer`

## Requirements
- R1: While `enable` is low, `trip` and `regulate` are low one cycle later and all timing is cleared, so after re-enabling a nominal overcurrent needs the full tick count again; reset gives the same idle state.
- R2: With `reg_en` low, a nominal overcurrent held high trips one cycle after the Nth tick it sees, where N is FILT_T0, FILT_T1, FILT_T2 or FILT_T3 for `filt_sel` 00, 01, 10 or 11.
- R3: A drop of `over_nom` for a single cycle clears the filter count, so a later overcurrent again needs all N ticks.
- R4: `qt_sel` is decoded as 00 = 100 mV (the reset-friendly default), 01 = 60 mV, 10 = 200 mV and 11 = off. `qt_level` encodes 00 = off, 01 = 60 mV, 10 = 100 mV and 11 = 200 mV.
- R5: When the fast limit is on, `over_quick` high trips on the next cycle without waiting for any tick, in both filter mode and regulation mode.
- R6: When `qt_sel` is 11, `over_quick` has no effect on `trip`.
- R7: With `reg_en` high, `over_nom` raises `regulate` on the next cycle, and the filter count does not trip the breaker.
- R8: In regulation mode, a nominal overcurrent held high trips one cycle after the Mth tick, where M is REG_T0, REG_T1 or REG_T2 for `reg_sel` 00, 01 or 1x. `regulate` falls in the same cycle that `trip` rises.
- R9: If `over_nom` falls during regulation, `regulate` is low on the next cycle and the regulation timer restarts from zero.
- R10: `trip` is a single-cycle pulse. After a trip, no further `trip` or `regulate` occurs until `enable` has been low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Arms the breaker; low clears all timing and the trip latch |
| tick | input | 1 | Single-cycle timebase pulse |
| over_nom | input | 1 | Sense above nominal limit |
| over_quick | input | 1 | Sense above fast limit |
| filt_sel | input | 2 | Filter delay select |
| qt_sel | input | 2 | Fast limit select |
| reg_en | input | 1 | Current regulation enable |
| reg_sel | input | 2 | Regulation period select |
| trip | output | 1 | Breaker trip pulse |
| regulate | output | 1 | Request to pull back gate drive |
| qt_level | output | 2 | Threshold code for the fast comparator |

## Verification
The hardest state to reach is a regulation window that recovers late. The timer has to get within a few ticks of its limit, the overcurrent has to clear for one cycle, and the bench must then show that the whole period is counted again, not only what was left of it. The stimulus counts ticks one at a time under a held overcurrent and drops the flag at a chosen tick. It then checks that nothing trips at M−1 ticks after the restart and that the breaker trips exactly at M. The same one-tick-at-a-time approach probes the filter glitch case and the case where the block is disabled in the middle of a count.

// File: rtl/ocb_timer.sv
module ocb_timer #(
  parameter int CW      = 20,
  parameter int FILT_T0 = 5,
  parameter int FILT_T1 = 50,
  parameter int FILT_T2 = 150,
  parameter int FILT_T3 = 400,
  parameter int REG_T0  = 5000,
  parameter int REG_T1  = 80000,
  parameter int REG_T2  = 320000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       tick,
  input  logic       over_nom,
  input  logic       over_quick,
  input  logic [1:0] filt_sel,
  input  logic [1:0] qt_sel,
  input  logic       reg_en,
  input  logic [1:0] reg_sel,
  output logic       trip,
  output logic       regulate,
  output logic [1:0] qt_level
);

  localparam logic [CW-1:0] F0 = CW'(FILT_T0 - 1);
  localparam logic [CW-1:0] F1 = CW'(FILT_T1 - 1);
  localparam logic [CW-1:0] F2 = CW'(FILT_T2 - 1);
  localparam logic [CW-1:0] F3 = CW'(FILT_T3 - 1);
  localparam logic [CW-1:0] P0 = CW'(REG_T0 - 1);
  localparam logic [CW-1:0] P1 = CW'(REG_T1 - 1);
  localparam logic [CW-1:0] P2 = CW'(REG_T2 - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] filt_lim;
  logic [CW-1:0] reg_lim;
  logic [CW-1:0] lim;
  logic          tripped;
  logic          qt_on;
  logic          qt_hit;
  logic          span_done;
  logic          fire;

  always_comb begin
    case (qt_sel)
      2'b00:   qt_level = 2'b10;
      2'b01:   qt_level = 2'b01;
      2'b10:   qt_level = 2'b11;
      default: qt_level = 2'b00;
    endcase
  end

  always_comb begin
    case (filt_sel)
      2'b00:   filt_lim = F0;
      2'b01:   filt_lim = F1;
      2'b10:   filt_lim = F2;
      default: filt_lim = F3;
    endcase
  end

  always_comb begin
    case (reg_sel)
      2'b00:   reg_lim = P0;
      2'b01:   reg_lim = P1;
      default: reg_lim = P2;
    endcase
  end

  assign lim       = reg_en ? reg_lim : filt_lim;
  assign qt_on     = (qt_level != 2'b00);
  assign qt_hit    = qt_on && over_quick;
  assign span_done = over_nom && tick && (cnt >= lim);
  assign fire      = enable && !tripped && (qt_hit || span_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      tripped  <= 1'b0;
      trip     <= 1'b0;
      regulate <= 1'b0;
    end else begin
      trip     <= fire;
      regulate <= enable && !tripped && !fire && reg_en && over_nom;
      if (!enable)
        tripped <= 1'b0;
      else if (fire)
        tripped <= 1'b1;
      if (!enable || tripped || fire || !over_nom)
        cnt <= '0;
      else if (tick)
        cnt <= cnt + 1'b1;
    end
  end

  p_disable_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!trip && !regulate));

  p_trip_has_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trip |-> $past(over_nom || over_quick));

  p_quick_now_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !tripped && qt_on && over_quick) |=> trip);

  p_reg_needs_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    regulate |-> $past(reg_en && over_nom && enable));

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> !trip);

endmodule

// File: tb/test_ocb_timer.sv
`timescale 1ns/1ps
module test_ocb_timer;
  localparam int FT0 = 3, FT1 = 5, FT2 = 8, FT3 = 12;
  localparam int RT0 = 20, RT1 = 30, RT2 = 40;

  logic clk = 0;
  logic rst_n = 0;
  logic enable = 0, tick = 0, over_nom = 0, over_quick = 0, reg_en = 0;
  logic [1:0] filt_sel = 0, qt_sel = 0, reg_sel = 0;
  logic trip, regulate;
  logic [1:0] qt_level;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  ocb_timer #(.CW(8), .FILT_T0(FT0), .FILT_T1(FT1), .FILT_T2(FT2), .FILT_T3(FT3),
              .REG_T0(RT0), .REG_T1(RT1), .REG_T2(RT2)) i_ocb_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .over_nom(over_nom),
    .over_quick(over_quick), .filt_sel(filt_sel), .qt_sel(qt_sel), .reg_en(reg_en),
    .reg_sel(reg_sel), .trip(trip), .regulate(regulate), .qt_level(qt_level));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic tick_once();
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
  endtask

  task automatic ticks_quiet(int n, string req);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      tick_once();
      if (trip) seen = 1;
    end
    check(req, seen, 0);
  endtask

  task automatic rearm();
    @(negedge clk);
    over_nom = 0; over_quick = 0; enable = 0;
    @(negedge clk) enable = 1;
  endtask

  task automatic t_reset();
    check("R1 trip after reset", trip, 0);
    check("R1 regulate after reset", regulate, 0);
    check("R4 default level", qt_level, 2);
  endtask

  task automatic t_qt_codes();
    int exp [4] = '{2, 1, 3, 0};
    for (int c = 0; c < 4; c++) begin
      @(negedge clk) qt_sel = 2'(c);
      #1 check($sformatf("R4 qt_sel %0d", c), qt_level, exp[c]);
    end
    @(negedge clk) qt_sel = 2'b00;
  endtask

  task automatic t_filter(int sel, int n);
    rearm();
    reg_en = 0; filt_sel = 2'(sel);
    over_nom = 1;
    ticks_quiet(n - 1, $sformatf("R2 no early trip sel %0d", sel));
    tick_once();
    check($sformatf("R2 trip at tick %0d", n), trip, 1);
    step();
    check("R10 trip one cycle", trip, 0);
    ticks_quiet(n + 2, "R10 latched quiet");
    check("R10 regulate quiet", regulate, 0);
  endtask

  task automatic t_glitch();
    rearm();
    reg_en = 0; filt_sel = 2'b01; over_nom = 1;
    ticks_quiet(FT1 - 1, "R3 pre glitch");
    @(negedge clk) over_nom = 0;
    @(negedge clk) over_nom = 1;
    ticks_quiet(FT1 - 1, "R3 count restarted");
    tick_once();
    check("R3 trip after full count", trip, 1);
  endtask

  task automatic t_disable_mid();
    rearm();
    reg_en = 0; filt_sel = 2'b01; over_nom = 1;
    ticks_quiet(FT1 - 1, "R1 pre disable");
    @(negedge clk) enable = 0;
    @(negedge clk);
    check("R1 trip while disabled", trip, 0);
    check("R1 regulate while disabled", regulate, 0);
    enable = 1;
    ticks_quiet(FT1 - 1, "R1 count cleared");
    tick_once();
    check("R1 trip after re-enable", trip, 1);
  endtask

  task automatic t_quick(bit mode);
    rearm();
    reg_en = mode; qt_sel = 2'b10;
    @(negedge clk) over_quick = 1;
    @(negedge clk);
    check($sformatf("R5 quick trip mode %0d", mode), trip, 1);
    @(negedge clk);
    check("R10 quick trip single", trip, 0);
    qt_sel = 2'b00;
  endtask

  task automatic t_quick_off();
    rearm();
    reg_en = 0; qt_sel = 2'b11;
    over_quick = 1;
    ticks_quiet(FT3 + 4, "R6 quick ignored when off");
    qt_sel = 2'b00;
    over_quick = 0;
  endtask

  task automatic t_reg(int sel, int m);
    rearm();
    reg_en = 1; reg_sel = 2'(sel); filt_sel = 2'b00;
    @(negedge clk) over_nom = 1;
    @(negedge clk);
    check("R7 regulate raised", regulate, 1);
    ticks_quiet(m - 1, $sformatf("R7 no filter trip, period sel %0d", sel));
    check("R8 regulate held", regulate, 1);
    tick_once();
    check($sformatf("R8 trip at tick %0d", m), trip, 1);
    check("R8 regulate falls with trip", regulate, 0);
  endtask

  task automatic t_recover();
    rearm();
    reg_en = 1; reg_sel = 2'b00;
    over_nom = 1;
    ticks_quiet(RT0 - 2, "R9 pre recovery");
    @(negedge clk) over_nom = 0;
    @(negedge clk);
    check("R9 regulate drops", regulate, 0);
    over_nom = 1;
    ticks_quiet(RT0 - 1, "R9 timer restarted");
    check("R9 regulate back", regulate, 1);
    tick_once();
    check("R9 trip after full period", trip, 1);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_qt_codes();
    t_filter(0, FT0);
    t_filter(1, FT1);
    t_filter(2, FT2);
    t_filter(3, FT3);
    t_glitch();
    t_disable_mid();
    t_quick(0);
    t_quick(1);
    t_quick_off();
    t_reg(0, RT0);
    t_reg(1, RT1);
    t_reg(2, RT2);
    t_reg(3, RT2);
    t_recover();
    rearm();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule